// File: doc/BRIEF.md
# DMA Channel Control/Status and Interrupt Summary Bank

This block holds the software-visible control and status word of every channel of a multi-channel DMA controller. It also holds a global summary word with one pending bit per channel. Software reaches both through a 32-bit register port. Writes take effect on the clock edge. Reads are combinational from the address.

Each channel word carries three things:
- A run control and two mode enables.
- Three sticky event flags that software clears by writing 1.
- Two read-only status bits: the stop state, and a mirror of the channel's request line.

The channel engines send one-cycle event pulses, and those pulses set the flags. An engine's stop pulse drops that channel's run bit. A single interrupt output is raised while any summary bit is set. A handler on a shared line reads the summary word to find the channels that need service.

Top module: `dma_chan_csr_bank`

## Requirements
- R1: After reset:
  - every run, mode-enable and event flag is 0;
  - every channel word reads with only the stop bit (bit 3) set, plus bit 8 if that channel's request input is high;
  - the summary word reads 0;
  - `irq_o` is 0.
- R2: Channel n's word is at byte offset 4*n, for n below `NUM_CH`. Its bits are:
  - bit 31: run;
  - bit 30: no-descriptor-fetch mode;
  - bit 29: stop-interrupt enable;
  - bit 8: the live value of `dreq[n]`;
  - bit 3: stop state;
  - bit 2: end flag;
  - bit 1: start flag;
  - bit 0: bus-error flag.

  All other bits read 0.
- R3: A write to channel n loads bits 31, 30 and 29 from the write data on the next edge. `run_o[n]` and `nodesc_o[n]` follow the stored values.
- R4: An `evt_stop[n]` pulse clears the run bit on the next edge, and it wins over a write of run=1 in the same cycle. The stop-state bit reads as the inverse of the run bit.
- R5: In the cycle of an `evt_end[n]` pulse, the end flag sets only if `cmd_end_ie[n]` is high. In the cycle of an `evt_start[n]` pulse, the start flag sets only if `cmd_start_ie[n]` is high. An `evt_buserr[n]` pulse always sets the bus-error flag.
- R6: Writing 1 to flag bit 0, 1 or 2 of a channel word clears that flag, and writing 0 leaves it unchanged. Writing back a value just read therefore clears exactly the flags that were set.
- R7: When a set event and a write-1-to-clear reach the same flag in the same cycle, the flag ends up set.
- R8: The summary word sits at byte offset 0xF0 and is read-only; writes to it change nothing. Its bit n is 1 exactly when channel n has any of these:
  - the end flag set;
  - the bus-error flag set;
  - the stop state together with the stop-interrupt enable.

  Bits at or above `NUM_CH` read 0.
- R9: `irq_o` is 1 exactly when the summary word is nonzero.
- R10: Any other address reads 0, and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_start | input | NUM_CH | Per-channel start event pulse |
| evt_end | input | NUM_CH | Per-channel end event pulse |
| evt_buserr | input | NUM_CH | Per-channel bus error pulse |
| evt_stop | input | NUM_CH | Per-channel stop-reached pulse |
| cmd_start_ie | input | NUM_CH | Start-interrupt enable of the active command |
| cmd_end_ie | input | NUM_CH | End-interrupt enable of the active command |
| dreq | input | NUM_CH | Peripheral request lines, mirrored in bit 8 |
| run_o | output | NUM_CH | Run bit per channel |
| nodesc_o | output | NUM_CH | No-descriptor-fetch mode per channel |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench tries the block with three kinds of traffic.

- Random mixed traffic. Random writes to channel words, the summary and unmapped addresses are interleaved with sparse random event pulses and enables. This separates correct per-channel decode from crosstalk between neighbouring channels.
- Directed collisions. Stop against run=1 and end-event against clear are each driven in a single cycle. This tells apart a design where the event wins from one where the write wins.
- Read-value write-backs. Writing back a value just read shows that only the seen flags clear. Enabled and disabled command interrupts show that the start and end flags are gated while bus error is not.

// File: rtl/dcsr_pkg.sv
// Package: bit positions of the channel control/status word.
// Assumes 32-bit register words; positions are decoded by software.
package dcsr_pkg;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned B_RUN     = 31;
    localparam int unsigned B_NODESC  = 30;
    localparam int unsigned B_STOPIE  = 29;
    localparam int unsigned B_REQ     = 8;
    localparam int unsigned B_STOPST  = 3;
    localparam int unsigned B_END     = 2;
    localparam int unsigned B_START   = 1;
    localparam int unsigned B_BERR    = 0;

    // Stored state of one channel
    typedef struct packed {
        logic run;
        logic nodesc;
        logic stopie;
        logic f_end;
        logic f_start;
        logic f_berr;
    } chan_state_t;
endpackage

// File: rtl/dcsr_chan.sv
// Module: one channel's control/status word.
// Holds run, mode enables and sticky flags. Events take precedence over
// software writes in the same cycle. Assumes single-cycle event pulses.
module dcsr_chan
    import dcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [WORD_W-1:0] wdata,
    input  logic              evt_start,
    input  logic              evt_end,
    input  logic              evt_buserr,
    input  logic              evt_stop,
    input  logic              start_ie,
    input  logic              end_ie,
    input  logic              dreq,
    output logic [WORD_W-1:0] word,
    output logic              pend,
    output logic              run,
    output logic              nodesc
);
    chan_state_t st;
    logic        set_end, set_start;
    logic        stop_state;

    // Qualify the start/end events with the active command's enables
    always_comb begin
        set_end   = evt_end   & end_ie;
        set_start = evt_start & start_ie;
    end

    // Update the stored state from events and software writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
        end else begin
            if (evt_stop)    st.run <= 1'b0;
            else if (wr_hit) st.run <= wdata[B_RUN];
            if (wr_hit) begin
                st.nodesc <= wdata[B_NODESC];
                st.stopie <= wdata[B_STOPIE];
            end
            if (set_end)                      st.f_end <= 1'b1;
            else if (wr_hit && wdata[B_END])  st.f_end <= 1'b0;
            if (set_start)                     st.f_start <= 1'b1;
            else if (wr_hit && wdata[B_START]) st.f_start <= 1'b0;
            if (evt_buserr)                   st.f_berr <= 1'b1;
            else if (wr_hit && wdata[B_BERR]) st.f_berr <= 1'b0;
        end
    end

    // Assemble the readable word and the pending indication
    always_comb begin
        stop_state       = ~st.run;
        word             = '0;
        word[B_RUN]      = st.run;
        word[B_NODESC]   = st.nodesc;
        word[B_STOPIE]   = st.stopie;
        word[B_REQ]      = dreq;
        word[B_STOPST]   = stop_state;
        word[B_END]      = st.f_end;
        word[B_START]    = st.f_start;
        word[B_BERR]     = st.f_berr;
        pend             = st.f_end | st.f_berr | (stop_state & st.stopie);
        run              = st.run;
        nodesc           = st.nodesc;
    end
endmodule

// File: rtl/dcsr_rdmux.sv
// Module: read-data selection for the register bank.
// Channel words are word-aligned from offset 0; the summary sits at SUM_OFS.
// Assumes the channel region ends below SUM_OFS.
module dcsr_rdmux #(
    parameter int unsigned NUM_CH  = 32,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned SUM_OFS = 'hF0
) (
    input  logic [NUM_CH-1:0][31:0] words,
    input  logic [NUM_CH-1:0]       pend,
    input  logic [ADDR_W-1:0]       addr,
    output logic [31:0]             rdata
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             in_chan;

    // Decode the channel index and region
    always_comb begin
        idx     = addr[ADDR_W-1:2];
        in_chan = (addr[1:0] == 2'b00) && (int'(idx) < int'(NUM_CH));
    end

    // Select the word for the addressed register
    always_comb begin
        rdata = '0;
        if (in_chan) begin
            for (int i = 0; i < int'(NUM_CH); i++)
                if (int'(idx) == i) rdata = words[i];
        end else if (addr == ADDR_W'(SUM_OFS)) begin
            rdata[NUM_CH-1:0] = pend;
        end
    end
endmodule

// File: rtl/dma_chan_csr_bank.sv
// Module: top of the per-channel control/status bank with interrupt summary.
// Decodes register writes to channel words, gathers pending bits and drives
// the combined interrupt. Assumes NUM_CH <= 32 and ADDR_W >= 8.
module dma_chan_csr_bank #(
    parameter int unsigned NUM_CH  = 32,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned SUM_OFS = 'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NUM_CH-1:0] evt_start,
    input  logic [NUM_CH-1:0] evt_end,
    input  logic [NUM_CH-1:0] evt_buserr,
    input  logic [NUM_CH-1:0] evt_stop,
    input  logic [NUM_CH-1:0] cmd_start_ie,
    input  logic [NUM_CH-1:0] cmd_end_ie,
    input  logic [NUM_CH-1:0] dreq,
    output logic [NUM_CH-1:0] run_o,
    output logic [NUM_CH-1:0] nodesc_o,
    output logic              irq_o
);
    logic [NUM_CH-1:0][31:0] words;
    logic [NUM_CH-1:0]       pend;
    logic [NUM_CH-1:0]       wr_hit;

    for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_ch
        // Write decode for this channel's word
        always_comb wr_hit[g] = reg_wr && (reg_addr == ADDR_W'(4 * g));

        dcsr_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_hit     (wr_hit[g]),
            .wdata      (reg_wdata),
            .evt_start  (evt_start[g]),
            .evt_end    (evt_end[g]),
            .evt_buserr (evt_buserr[g]),
            .evt_stop   (evt_stop[g]),
            .start_ie   (cmd_start_ie[g]),
            .end_ie     (cmd_end_ie[g]),
            .dreq       (dreq[g]),
            .word       (words[g]),
            .pend       (pend[g]),
            .run        (run_o[g]),
            .nodesc     (nodesc_o[g])
        );
    end

    dcsr_rdmux #(
        .NUM_CH  (NUM_CH),
        .ADDR_W  (ADDR_W),
        .SUM_OFS (SUM_OFS)
    ) u_rdmux (
        .words (words),
        .pend  (pend),
        .addr  (reg_addr),
        .rdata (reg_rdata)
    );

    // Combine the pending bits into one interrupt line
    always_comb irq_o = |pend;
endmodule

// File: rtl/dcsr_chk.sv
// Module: assertion checker bound to dma_chan_csr_bank.
// Observes ports only; each property is tagged with its requirement.
module dcsr_chk #(
    parameter int unsigned NUM_CH = 32,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [NUM_CH-1:0] evt_end,
    input logic [NUM_CH-1:0] evt_buserr,
    input logic [NUM_CH-1:0] evt_stop,
    input logic [NUM_CH-1:0] cmd_end_ie,
    input logic [NUM_CH-1:0] run_o,
    input logic              irq_o
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (run_o == '0) && !irq_o);

    for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_a
        // R4
        stop_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_stop[g] |=> !run_o[g]);
        // R3
        run_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == ADDR_W'(4 * g) && !evt_stop[g])
            |=> run_o[g] == $past(reg_wdata[31]));
        // R5
        buserr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_buserr[g] |=> irq_o);
        // R7
        end_event_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_end[g] && cmd_end_ie[g]) |=> irq_o);
    end
endmodule

bind dma_chan_csr_bank dcsr_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dcsr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .evt_end    (evt_end),
    .evt_buserr (evt_buserr),
    .evt_stop   (evt_stop),
    .cmd_end_ie (cmd_end_ie),
    .run_o      (run_o),
    .irq_o      (irq_o)
);

// File: tb/test_dma_chan_csr_bank.sv
// Bench: directed corners plus seeded random traffic against a bench model.
module test_dma_chan_csr_bank;
    localparam int NCH = 32;
    localparam int AW  = 8;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           reg_wr;
    logic [AW-1:0]  reg_addr;
    logic [31:0]    reg_wdata;
    logic [31:0]    reg_rdata;
    logic [NCH-1:0] evt_start, evt_end, evt_buserr, evt_stop;
    logic [NCH-1:0] cmd_start_ie, cmd_end_ie, dreq, run_o, nodesc_o;
    logic           irq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // model state
    bit m_run[NCH], m_nd[NCH], m_sie[NCH], m_end[NCH], m_st[NCH], m_be[NCH];

    always #2 clk = ~clk;

    dma_chan_csr_bank i_dma_chan_csr_bank (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_start(evt_start),
        .evt_end(evt_end), .evt_buserr(evt_buserr), .evt_stop(evt_stop),
        .cmd_start_ie(cmd_start_ie), .cmd_end_ie(cmd_end_ie), .dreq(dreq),
        .run_o(run_o), .nodesc_o(nodesc_o), .irq_o(irq_o));

    function automatic logic [31:0] exp_word(int i);
        logic [31:0] w = '0;
        w[31] = m_run[i]; w[30] = m_nd[i]; w[29] = m_sie[i];
        w[8] = dreq[i]; w[3] = !m_run[i];
        w[2] = m_end[i]; w[1] = m_st[i]; w[0] = m_be[i];
        return w;
    endfunction

    function automatic logic [31:0] exp_sum();
        logic [31:0] s = '0;
        for (int i = 0; i < NCH; i++)
            s[i] = m_end[i] | m_be[i] | (!m_run[i] & m_sie[i]);
        return s;
    endfunction

    function automatic logic [31:0] exp_read(logic [AW-1:0] a);
        if (a[1:0] == 2'b00 && int'(a[AW-1:2]) < NCH) return exp_word(int'(a[AW-1:2]));
        if (a == 8'hF0) return exp_sum();
        return '0;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic model_update();
        for (int i = 0; i < NCH; i++) begin
            bit hit = reg_wr && reg_addr == AW'(4 * i);
            if (evt_stop[i]) m_run[i] = 0; else if (hit) m_run[i] = reg_wdata[31];
            if (hit) begin m_nd[i] = reg_wdata[30]; m_sie[i] = reg_wdata[29]; end
            if (evt_end[i] && cmd_end_ie[i]) m_end[i] = 1; else if (hit && reg_wdata[2]) m_end[i] = 0;
            if (evt_start[i] && cmd_start_ie[i]) m_st[i] = 1; else if (hit && reg_wdata[1]) m_st[i] = 0;
            if (evt_buserr[i]) m_be[i] = 1; else if (hit && reg_wdata[0]) m_be[i] = 0;
        end
    endtask

    task automatic clear_stim();
        reg_wr = 0; reg_wdata = '0;
        evt_start = '0; evt_end = '0; evt_buserr = '0; evt_stop = '0;
    endtask

    // one clock: stimulus already applied; update model, then check after edge
    task automatic tick(string tag);
        @(posedge clk);
        model_update();
        #1;
        chk(tag, reg_rdata, exp_read(reg_addr));
        chk({tag, " irq R9"}, 32'(irq_o), 32'(exp_sum() != 0));
        @(negedge clk);
        clear_stim();
    endtask

    task automatic rd(logic [AW-1:0] a, string tag);
        reg_addr = a; #1;
        chk(tag, reg_rdata, exp_read(a));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(1234));
        rst_n = 0; clear_stim(); reg_addr = '0;
        cmd_start_ie = '0; cmd_end_ie = '0; dreq = 32'h0000_0005;
        for (int i = 0; i < NCH; i++) begin
            m_run[i] = 0; m_nd[i] = 0; m_sie[i] = 0; m_end[i] = 0; m_st[i] = 0; m_be[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1 reset state, R2 layout of request bit
        rd(8'h00, "R1 ch0 reset word");
        rd(8'h04, "R1 ch1 reset word");
        rd(8'h7C, "R1 ch31 reset word");
        rd(8'hF0, "R1 summary reset");
        chk("R1 irq reset", 32'(irq_o), 0);
        // R3 run/mode write on ch5
        reg_wr = 1; reg_addr = 8'h14; reg_wdata = 32'hC000_0000; tick("R3 write ch5");
        chk("R3 run_o", 32'(run_o[5]), 1);
        chk("R3 nodesc_o", 32'(nodesc_o[5]), 1);
        // R4 stop beats run write
        reg_wr = 1; reg_addr = 8'h14; reg_wdata = 32'h8000_0000; evt_stop[5] = 1; tick("R4 stop wins");
        chk("R4 run dropped", 32'(run_o[5]), 0);
        // R8 stop with stop-ie pends; R9 irq
        reg_wr = 1; reg_addr = 8'h18; reg_wdata = 32'h2000_0000; tick("R8 stopie ch6");
        rd(8'hF0, "R8 summary stop pend");
        reg_wr = 1; reg_addr = 8'h18; reg_wdata = 32'h0; tick("R8 stopie off");
        // R5 gated events
        cmd_end_ie[2] = 0; cmd_start_ie[2] = 0; evt_end[2] = 1; evt_start[2] = 1; reg_addr = 8'h08;
        tick("R5 disabled end/start ignored");
        cmd_end_ie[2] = 1; cmd_start_ie[2] = 1; evt_end[2] = 1; evt_start[2] = 1; evt_buserr[3] = 1;
        reg_addr = 8'h08; tick("R5 enabled end/start set");
        rd(8'h0C, "R5 buserr always sets");
        // R6 write-back of value read clears seen flags
        reg_addr = 8'h08; #1; v = reg_rdata;
        reg_wr = 1; reg_wdata = v; tick("R6 write-back clears");
        // R7 event beats clear
        reg_wr = 1; reg_addr = 8'h0C; reg_wdata = 32'h1; evt_buserr[3] = 1; tick("R7 set wins over clear");
        // R8 summary writes ignored, R10 unmapped
        reg_wr = 1; reg_addr = 8'hF0; reg_wdata = 32'hFFFF_FFFF; tick("R8 summary write ignored");
        reg_wr = 1; reg_addr = 8'h80; reg_wdata = 32'hFFFF_FFFF; tick("R10 unmapped 0x80");
        reg_wr = 1; reg_addr = 8'hFC; reg_wdata = 32'hFFFF_FFFF; tick("R10 unmapped 0xFC");
        rd(8'h0C, "R10 ch3 untouched");
        // random traffic covering R2..R9
        for (int n = 0; n < 400; n++) begin
            int c = $urandom_range(0, NCH - 1);
            int k = $urandom_range(0, 9);
            dreq = $urandom(); cmd_start_ie = $urandom(); cmd_end_ie = $urandom();
            evt_start  = $urandom() & $urandom() & $urandom();
            evt_end    = $urandom() & $urandom() & $urandom();
            evt_buserr = $urandom() & $urandom() & $urandom() & $urandom();
            evt_stop   = $urandom() & $urandom() & $urandom();
            reg_wr = ($urandom_range(0, 1) == 1);
            reg_wdata = $urandom();
            if (k < 7) reg_addr = AW'(4 * c);
            else if (k == 7) reg_addr = 8'hF0;
            else reg_addr = AW'($urandom());
            tick("R2 R6 random access");
        end
        for (int i = 0; i < NCH; i++) rd(AW'(4 * i), "R2 final sweep");
        rd(8'hF0, "R8 final summary");
        done = 1;
    end

    initial begin
        wait (done);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule